// File: doc/BRIEF.md
# Clock Compensation Rate Match FIFO

This block is a 16-entry elastic buffer placed between a write domain clocked by a recovered clock and a read domain clocked by a local clock. The two clocks are nominally equal but may differ by a few hundred ppm. The block keeps its fill level near the middle of the buffer. When the writer runs ahead, it discards incoming skip symbols. When the reader runs ahead, it sends a skip symbol a second time.

The write side accepts one 10-bit symbol per write clock, qualified by a valid flag. The read side emits one symbol on every read clock. Each side works out its own view of the occupancy. It does this by subtracting its own pointer from the other side's Gray-coded pointer after that pointer has passed through a two-flop synchronizer. A deletion or insertion is flagged by a one-cycle pulse in the domain where it happens. Full and empty are live flags. Overflow and underflow are sticky flags that stay set until reset.

One asynchronous active-low reset drives both domains. A synchronizer in each domain releases it on that domain's clock.

Top module: `ccf_top`

## Requirements
- R1: After reset, rd_sym equals the skip value (default 10'h0FA), rd_ins_pulse, wr_drop_pulse, wr_full, wr_overflow and rd_underflow are 0, and rd_empty is 1.
- R2: When a valid incoming symbol equals the skip value and the write-side occupancy is above HI_TH (default 12), the symbol is not stored, and wr_drop_pulse is high for the following write cycle. After a drop, a further drop waits until the synchronized read pointer changes.
- R3: When the read-side occupancy is below LO_TH (default 4) and the next stored symbol is the skip value, the block outputs the skip value, holds the read pointer for that cycle, and pulses rd_ins_pulse in the same cycle. After an insertion, a further insertion waits until the synchronized write pointer changes.
- R4: wr_full is high when the write-side occupancy equals 16. While it is high, the write pointer does not advance and incoming symbols are discarded.
- R5: rd_empty is high when the read-side occupancy is 0. While it is high, the read pointer does not advance and rd_sym shows the skip value.
- R6: A valid write that finds the buffer full sets wr_overflow. A read cycle that finds the buffer empty after start-up sets rd_underflow. Both flags stay set until reset.
- R7: Both pointers cross domains in Gray code, so that no more than one bit changes per clock, and each passes through two flops in the receiving domain.
- R8: Non-skip symbols reach rd_sym in write order, with none lost or repeated, under clock offsets of ±1 % (well beyond ±300 ppm) when the input carries a skip at least every fourth symbol.
- R9: After reset, the reader pops nothing and leaves rd_underflow clear until its occupancy view reaches (HI_TH+LO_TH)/2. Until then it outputs the skip value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Recovered (write) clock |
| wr_valid | input | 1 | Write symbol qualifier |
| wr_sym | input | 10 | Incoming symbol |
| wr_full | output | 1 | Buffer full, as seen from the write side |
| wr_overflow | output | 1 | Sticky: a write was discarded while full |
| wr_drop_pulse | output | 1 | One write cycle pulse per deleted skip symbol |
| rd_clk | input | 1 | Local (read) clock |
| rd_sym | output | 10 | Outgoing symbol, one per read clock |
| rd_empty | output | 1 | Buffer empty, as seen from the read side |
| rd_underflow | output | 1 | Sticky: a read cycle found the buffer empty |
| rd_ins_pulse | output | 1 | One read cycle pulse per inserted skip symbol |

## Verification
The assertions check on every cycle that the pointers move by single-bit Gray steps, and that no pointer advances while full or empty. They also check that a drop pulse only follows a valid skip symbol, that an insertion both outputs the skip value and freezes the read pointer, and that the sticky flags never clear. Only the bench's scenarios can show that the compensation actually holds the level when the write clock is faster or slower. The same applies to end-to-end ordering and loss-free delivery of the data symbols, the start-up gate, and overflow and underflow being reached when the stream is stopped or carries no skips.

// File: rtl/ccf_pkg.sv
// Shared definitions for the clock compensation FIFO.
// Assumes symbols are SYM_W bits and pointers carry one extra wrap bit.
package ccf_pkg;
    localparam int SYM_W_DEF = 10;

    // What the read side does in one read clock cycle.
    typedef enum logic [1:0] {
        RA_IDLE   = 2'd0,   // not yet started after reset, send skip
        RA_POP    = 2'd1,   // deliver stored symbol, advance pointer
        RA_INSERT = 2'd2,   // repeat skip, hold pointer
        RA_EMPTY  = 2'd3    // nothing stored, send skip, flag underflow
    } rd_act_t;
endpackage

// File: rtl/ccf_reset_sync.sv
// Reset release synchronizer: asserts asynchronously, releases on the
// second rising edge of clk after arst_n rises.
module ccf_reset_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic stage1;

    // Two-flop release chain.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= 1'b0;
            srst_n <= 1'b0;
        end else begin
            stage1 <= 1'b1;
            srst_n <= stage1;
        end
    end
endmodule

// File: rtl/ccf_ptr_sync.sv
// Brings a Gray-coded pointer into the destination domain through two
// flops and converts it back to binary. Assumes the source changes by at
// most one bit per source clock.
module ccf_ptr_sync #(
    parameter int W = 5
) (
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-flop synchronizer.
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the XOR of all higher Gray bits.
    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_out[i] = ^sync_q[W-1:i];
    end
endmodule

// File: rtl/ccf_store.sv
// Register-file storage: one write port on the write clock, one
// combinational read port used by the read domain. The read address is
// assumed to point only at entries the synchronized write pointer covers.
module ccf_store #(
    parameter int AW    = 4,
    parameter int SYM_W = 10
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [SYM_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [SYM_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [SYM_W-1:0] mem [DEPTH];

    // Write port, no reset needed on data.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ccf_wr_ctl.sv
// Write-domain control: decides per incoming symbol whether to store it,
// drop it (skip symbol while above the high threshold) or discard it
// (buffer full). Keeps the binary and Gray write pointers.
module ccf_wr_ctl #(
    parameter int               AW       = 4,
    parameter int               SYM_W    = 10,
    parameter logic [SYM_W-1:0] SKIP_SYM = 10'h0FA,
    parameter int               HI_TH    = 12
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_valid,
    input  logic [SYM_W-1:0] wr_sym,
    input  logic [AW:0]      rptr_sync,
    output logic [AW:0]      wptr,
    output logic [AW:0]      wgray,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic             wr_full,
    output logic             wr_overflow,
    output logic             wr_drop_pulse
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] level;
    logic [PW-1:0] wptr_nxt;
    logic [PW-1:0] rsync_q;
    logic          armed;
    logic          is_skip;
    logic          do_drop;
    logic          do_write;
    logic          do_discard;

    // Occupancy as seen from the write side, plus the per-symbol decision.
    always_comb begin
        level      = wptr - rptr_sync;
        wr_full    = (level == PW'(DEPTH));
        is_skip    = (wr_sym == SKIP_SYM);
        do_drop    = wr_valid && is_skip && armed && (level > PW'(HI_TH));
        do_write   = wr_valid && !do_drop && !wr_full;
        do_discard = wr_valid && !do_drop && wr_full;
        wptr_nxt   = wptr + PW'(1);
    end

    assign mem_we    = do_write;
    assign mem_waddr = wptr[AW-1:0];

    // Pointer advance in binary and Gray form.
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (do_write) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // Drop re-arm: one drop, then wait for the read pointer view to move.
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            armed   <= 1'b1;
            rsync_q <= '0;
        end else begin
            rsync_q <= rptr_sync;
            if (do_drop)                    armed <= 1'b0;
            else if (rptr_sync != rsync_q)  armed <= 1'b1;
        end
    end

    // Status: drop pulse and sticky overflow.
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wr_drop_pulse <= 1'b0;
            wr_overflow   <= 1'b0;
        end else begin
            wr_drop_pulse <= do_drop;
            if (do_discard) wr_overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/ccf_rd_ctl.sv
// Read-domain control: emits one symbol per read clock. It waits after
// reset until the level reaches the midpoint, repeats a skip symbol when
// below the low threshold, and sends skip while empty.
module ccf_rd_ctl
    import ccf_pkg::*;
#(
    parameter int               AW       = 4,
    parameter int               SYM_W    = 10,
    parameter logic [SYM_W-1:0] SKIP_SYM = 10'h0FA,
    parameter int               HI_TH    = 12,
    parameter int               LO_TH    = 4
) (
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic [AW:0]      wptr_sync,
    input  logic [SYM_W-1:0] head_sym,
    output logic [AW:0]      rptr,
    output logic [AW:0]      rgray,
    output logic [AW-1:0]    mem_raddr,
    output logic [SYM_W-1:0] rd_sym,
    output logic             rd_empty,
    output logic             rd_underflow,
    output logic             rd_ins_pulse
);
    localparam int PW       = AW + 1;
    localparam int START_TH = (HI_TH + LO_TH) / 2;

    logic [PW-1:0] level;
    logic [PW-1:0] rptr_nxt;
    logic [PW-1:0] wsync_q;
    logic          started;
    logic          armed;
    rd_act_t       act;

    // Occupancy seen from the read side and the action for this cycle.
    always_comb begin
        level    = wptr_sync - rptr;
        rd_empty = (level == '0);
        rptr_nxt = rptr + PW'(1);
        if (!started)
            act = RA_IDLE;
        else if (rd_empty)
            act = RA_EMPTY;
        else if ((head_sym == SKIP_SYM) && armed && (level < PW'(LO_TH)))
            act = RA_INSERT;
        else
            act = RA_POP;
    end

    assign mem_raddr = rptr[AW-1:0];

    // Pointer advance in binary and Gray form.
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rptr  <= '0;
            rgray <= '0;
        end else if (act == RA_POP) begin
            rptr  <= rptr_nxt;
            rgray <= rptr_nxt ^ (rptr_nxt >> 1);
        end
    end

    // Output symbol register.
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)          rd_sym <= SKIP_SYM;
        else if (act == RA_POP) rd_sym <= head_sym;
        else                    rd_sym <= SKIP_SYM;
    end

    // Start-up gate: begin reading once half way between thresholds.
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)                    started <= 1'b0;
        else if (level >= PW'(START_TH))  started <= 1'b1;
    end

    // Insert re-arm: one insertion, then wait for the write pointer view to move.
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            armed   <= 1'b1;
            wsync_q <= '0;
        end else begin
            wsync_q <= wptr_sync;
            if (act == RA_INSERT)           armed <= 1'b0;
            else if (wptr_sync != wsync_q)  armed <= 1'b1;
        end
    end

    // Status: insertion pulse and sticky underflow.
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rd_ins_pulse <= 1'b0;
            rd_underflow <= 1'b0;
        end else begin
            rd_ins_pulse <= (act == RA_INSERT);
            if (act == RA_EMPTY) rd_underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/ccf_top.sv
// Clock compensation rate match FIFO: a dual-clock elastic buffer that
// holds its level between LO_TH and HI_TH by dropping or repeating skip
// symbols. Assumes the input stream carries skip symbols often enough
// to absorb the clock offset.
module ccf_top #(
    parameter int                      AW       = 4,
    parameter int                      SYM_W    = ccf_pkg::SYM_W_DEF,
    parameter logic [SYM_W-1:0]        SKIP_SYM = 10'h0FA,
    parameter int                      HI_TH    = 12,
    parameter int                      LO_TH    = 4
) (
    input  logic             rst_n,
    input  logic             wr_clk,
    input  logic             wr_valid,
    input  logic [SYM_W-1:0] wr_sym,
    output logic             wr_full,
    output logic             wr_overflow,
    output logic             wr_drop_pulse,
    input  logic             rd_clk,
    output logic [SYM_W-1:0] rd_sym,
    output logic             rd_empty,
    output logic             rd_underflow,
    output logic             rd_ins_pulse
);
    localparam int PW = AW + 1;

    logic             wr_srst_n;
    logic             rd_srst_n;
    logic [PW-1:0]    wptr, wgray, rptr, rgray;
    logic [PW-1:0]    rptr_sync, wptr_sync;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr, mem_raddr;
    logic [SYM_W-1:0] head_sym;

    ccf_reset_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
    ccf_reset_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

    ccf_ptr_sync #(.W(PW)) u_r2w (
        .dst_clk(wr_clk), .dst_rst_n(wr_srst_n),
        .gray_in(rgray), .bin_out(rptr_sync)
    );
    ccf_ptr_sync #(.W(PW)) u_w2r (
        .dst_clk(rd_clk), .dst_rst_n(rd_srst_n),
        .gray_in(wgray), .bin_out(wptr_sync)
    );

    ccf_store #(.AW(AW), .SYM_W(SYM_W)) u_store (
        .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_sym),
        .raddr(mem_raddr), .rdata(head_sym)
    );

    ccf_wr_ctl #(.AW(AW), .SYM_W(SYM_W), .SKIP_SYM(SKIP_SYM), .HI_TH(HI_TH)) u_wr (
        .wr_clk(wr_clk), .wr_rst_n(wr_srst_n),
        .wr_valid(wr_valid), .wr_sym(wr_sym), .rptr_sync(rptr_sync),
        .wptr(wptr), .wgray(wgray), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .wr_full(wr_full), .wr_overflow(wr_overflow), .wr_drop_pulse(wr_drop_pulse)
    );

    ccf_rd_ctl #(.AW(AW), .SYM_W(SYM_W), .SKIP_SYM(SKIP_SYM),
                 .HI_TH(HI_TH), .LO_TH(LO_TH)) u_rd (
        .rd_clk(rd_clk), .rd_rst_n(rd_srst_n),
        .wptr_sync(wptr_sync), .head_sym(head_sym),
        .rptr(rptr), .rgray(rgray), .mem_raddr(mem_raddr),
        .rd_sym(rd_sym), .rd_empty(rd_empty),
        .rd_underflow(rd_underflow), .rd_ins_pulse(rd_ins_pulse)
    );
endmodule

// File: rtl/ccf_checker.sv
// Cycle-level properties of the clock compensation FIFO, bound to ccf_top.
module ccf_checker #(
    parameter int               AW       = 4,
    parameter int               SYM_W    = 10,
    parameter logic [SYM_W-1:0] SKIP_SYM = 10'h0FA
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             wr_srst_n,
    input logic             rd_srst_n,
    input logic             wr_valid,
    input logic [SYM_W-1:0] wr_sym,
    input logic [AW:0]      wptr,
    input logic [AW:0]      wgray,
    input logic [AW:0]      rptr,
    input logic [AW:0]      rgray,
    input logic             wr_full,
    input logic             wr_overflow,
    input logic             wr_drop_pulse,
    input logic [SYM_W-1:0] rd_sym,
    input logic             rd_empty,
    input logic             rd_underflow,
    input logic             rd_ins_pulse
);
    assert_drop_only_skip_R2: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
        wr_drop_pulse |-> ($past(wr_valid) && $past(wr_sym) == SKIP_SYM));

    assert_insert_skip_R3: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        rd_ins_pulse |-> (rd_sym == SKIP_SYM && rptr == $past(rptr)));

    assert_no_write_full_R4: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
        wr_full |=> $stable(wptr));

    assert_no_pop_empty_R5: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        rd_empty |=> ($stable(rptr) && rd_sym == SKIP_SYM));

    assert_overflow_sticky_R6: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
        wr_overflow |=> wr_overflow);

    assert_underflow_sticky_R6: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        rd_underflow |=> rd_underflow);

    assert_wgray_step_R7: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_step_R7: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    assert_wptr_step_R7: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
        (wptr == $past(wptr)) || (wptr == $past(wptr) + 1'b1));
endmodule

bind ccf_top ccf_checker #(.AW(AW), .SYM_W(SYM_W), .SKIP_SYM(SKIP_SYM)) u_ccf_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk),
    .wr_srst_n(wr_srst_n), .rd_srst_n(rd_srst_n),
    .wr_valid(wr_valid), .wr_sym(wr_sym),
    .wptr(wptr), .wgray(wgray), .rptr(rptr), .rgray(rgray),
    .wr_full(wr_full), .wr_overflow(wr_overflow), .wr_drop_pulse(wr_drop_pulse),
    .rd_sym(rd_sym), .rd_empty(rd_empty),
    .rd_underflow(rd_underflow), .rd_ins_pulse(rd_ins_pulse)
);

// File: tb/tb_ccf_top.sv
`timescale 1ps/1ps
module tb_ccf_top;
    localparam logic [9:0] SKIP = 10'h0FA;
    localparam int RD_HALF = 2000;   // 250 MHz read clock

    logic       rst_n = 1'b0;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_valid = 1'b0;
    logic [9:0] wr_sym = SKIP;
    logic       wr_full, wr_overflow, wr_drop_pulse;
    logic [9:0] rd_sym;
    logic       rd_empty, rd_underflow, rd_ins_pulse;

    int wr_half = 2000;
    int n_checks = 0;
    int n_fail = 0;
    bit wr_run = 0;
    bit data_only = 0;
    bit chk_en = 0;
    int slot = 0;
    int dcount = 0;
    int exp_cnt = 0;
    int rx_cnt = 0;
    int drops = 0;
    int inserts = 0;
    bit saw_full = 0;
    bit saw_empty = 0;
    bit done = 0;

    ccf_top dut (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_sym(wr_sym),
        .wr_full(wr_full), .wr_overflow(wr_overflow), .wr_drop_pulse(wr_drop_pulse),
        .rd_clk(rd_clk), .rd_sym(rd_sym), .rd_empty(rd_empty),
        .rd_underflow(rd_underflow), .rd_ins_pulse(rd_ins_pulse)
    );

    always #(RD_HALF) rd_clk = ~rd_clk;
    always #(wr_half) wr_clk = ~wr_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Symbol source: data 0x100+(k%256), a skip every fourth slot unless data_only.
    always @(negedge wr_clk) begin
        if (wr_run) begin
            wr_valid = 1'b1;
            if (!data_only && (slot % 4 == 3)) wr_sym = SKIP;
            else begin
                wr_sym = 10'h100 + 10'(dcount % 256);
                dcount++;
            end
            slot++;
        end else begin
            wr_valid = 1'b0;
        end
        if (wr_drop_pulse) drops++;
        if (wr_full) saw_full = 1;
    end

    // Read monitor: data symbols must arrive in order (R8).
    always @(negedge rd_clk) begin
        if (rd_ins_pulse) inserts++;
        if (rd_empty) saw_empty = 1;
        if (rd_sym != SKIP) begin
            if (chk_en)
                check(rd_sym == 10'h100 + 10'(exp_cnt % 256), "R8 order",
                      int'(rd_sym), 32'h100 + exp_cnt % 256);
            exp_cnt++;
            rx_cnt++;
        end
    end

    task automatic do_reset();
        wr_run = 0;
        repeat (3) @(negedge wr_clk);
        rst_n = 1'b0;
        #20000;
        slot = 0; dcount = 0; exp_cnt = 0; rx_cnt = 0;
        drops = 0; inserts = 0; saw_full = 0; saw_empty = 0;
        rst_n = 1'b1;
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #200_000_000;
        if (!done) begin
            check(0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check(rd_sym == SKIP, "R1 rd_sym", int'(rd_sym), int'(SKIP));
        check(rd_empty == 1, "R1 empty", int'(rd_empty), 1);
        check(wr_full == 0, "R1 full", int'(wr_full), 0);
        check(wr_overflow == 0 && rd_underflow == 0, "R1 sticky", int'(wr_overflow + rd_underflow), 0);
        check(wr_drop_pulse == 0 && rd_ins_pulse == 0, "R1 pulses", int'(wr_drop_pulse + rd_ins_pulse), 0);

        // R9 start gate: idle reader does not flag underflow
        repeat (50) @(negedge rd_clk);
        check(rd_underflow == 0, "R9 no underflow before start", int'(rd_underflow), 0);
        check(rd_sym == SKIP, "R9 skip before start", int'(rd_sym), int'(SKIP));

        // R8 equal clocks
        chk_en = 1;
        wr_half = 2000;
        wr_run = 1;
        repeat (2000) @(negedge wr_clk);
        check(rd_underflow == 0 && wr_overflow == 0, "R8 equal no flags", int'(rd_underflow + wr_overflow), 0);

        // R2 write clock 1 % fast: skips dropped, no overflow
        drops = 0;
        wr_half = 1980;
        repeat (3000) @(negedge wr_clk);
        check(drops > 0, "R2 drops when fast", drops, 1);
        check(wr_overflow == 0, "R2 no overflow", int'(wr_overflow), 0);

        // R3 write clock 1 % slow: skips repeated, no underflow
        inserts = 0;
        wr_half = 2020;
        repeat (3000) @(negedge wr_clk);
        check(inserts > 0, "R3 inserts when slow", inserts, 1);
        check(rd_underflow == 0, "R3 no underflow", int'(rd_underflow), 0);

        // R5/R6 stop source: drain to empty
        wr_half = 2000;
        wr_run = 0;
        saw_empty = 0;
        repeat (200) @(negedge rd_clk);
        check(exp_cnt == dcount, "R8 all data delivered", exp_cnt, dcount);
        check(saw_empty == 1, "R5 empty seen", int'(saw_empty), 1);
        check(rd_sym == SKIP, "R5 skip while empty", int'(rd_sym), int'(SKIP));
        check(rd_underflow == 1, "R6 underflow set", int'(rd_underflow), 1);
        repeat (20) @(negedge rd_clk);
        check(rd_underflow == 1, "R6 underflow sticky", int'(rd_underflow), 1);

        // R4/R6 overflow: data only, write clock 10 % fast
        chk_en = 0;
        do_reset();
        check(rd_underflow == 0, "R1 underflow cleared", int'(rd_underflow), 0);
        data_only = 1;
        wr_half = 1800;
        wr_run = 1;
        repeat (600) @(negedge wr_clk);
        wr_run = 0;
        check(saw_full == 1, "R4 full seen", int'(saw_full), 1);
        check(drops == 0, "R2 no drop without skip", drops, 0);
        check(wr_overflow == 1, "R6 overflow set", int'(wr_overflow), 1);
        repeat (100) @(negedge wr_clk);
        check(wr_overflow == 1, "R6 overflow sticky", int'(wr_overflow), 1);
        check(rx_cnt < dcount, "R4 data discarded when full", rx_cnt, dcount);
        data_only = 0;
        do_reset();
        check(wr_overflow == 0, "R1 overflow cleared", int'(wr_overflow), 0);

        done = 1;
        summary();
    end
endmodule